// File: doc/BRIEF.md
# SDRAM Open-Page Latency Tracker

This block models the row state of an SDRAM with several banks. It keeps, for each bank, the page that is currently open. It takes one access request at a time, carrying a byte address, and decides whether the access lands in the page already open in its bank (a hit) or forces that bank onto a new page (a miss). After the modelled number of clocks it emits a one-cycle completion that carries the hit/miss verdict. For each bank it also keeps a saturating count of page switches, so that software can see which banks thrash.

Requests arrive on a valid/ready handshake. `req_ready` is the only back-pressure. A request transfers on a rising clock edge at which both `req_valid` and `req_ready` are high. `req_ready` stays low from that edge until the completion cycle. A requester that holds `req_valid` high while `req_ready` is low has not transferred anything, and that request is dropped, not queued. The completion side has no back-pressure: `cpl_valid` is a single-cycle pulse that the consumer must take when it appears. `busy` is a plain status pin and is the inverse of `req_ready`.

Top module: `sdram_page_tracker`

## Requirements
- R1: An address is split into three fields. Bits [OFFSET_W-1:0] (default [11:0], 4 KB) are the offset within the page. Bits [OFFSET_W+BANK_W-1:OFFSET_W] (default [13:12]) select one of 2^BANK_W banks (default 4). The remaining upper bits name the page. The offset never affects the verdict.
- R2: After reset no bank has an open page. The first access to each bank is therefore a miss with the miss latency. Opening a page in a closed bank does not increment that bank's counter.
- R3: An access whose page equals the page last opened in its bank is a hit (`cpl_hit`=1). If the access is accepted at edge k, `cpl_valid` is high during the cycle that follows edge k+HIT_LAT (HIT_LAT defaults to 3).
- R4: An access to a bank whose open page differs from the requested page, or to a closed bank, is a miss (`cpl_hit`=0). Its completion follows edge k+HIT_LAT+SWITCH_PEN (default 3+4=7), and that page becomes the bank's open page.
- R5: Banks are independent. An access to one bank leaves the open page of every other bank unchanged.
- R6: A miss in a bank that already had an open page increments that bank's counter by exactly one. The counters of the other banks do not change. Counter b sits at `thrash_cnt[b*CNT_W +: CNT_W]`.
- R7: Each counter saturates at all ones (2^CNT_W-1) and then holds that value.
- R8: `req_ready` is low and `busy` is high from the acceptance edge up to, but not including, the completion cycle. A request presented during that window has no effect on the verdicts, the counters or the completions.
- R9: `cpl_valid` is high for exactly one cycle per accepted request. `cpl_hit` is valid in that cycle.
- R10: After reset `req_ready`=1, `busy`=0, `cpl_valid`=0 and every counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can transfer this edge |
| req_addr | input | ADDR_W | Byte address of the request |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_hit | output | 1 | 1 = page hit, 0 = page miss; valid with cpl_valid |
| busy | output | 1 | A request is being timed |
| thrash_cnt | output | (2^BANK_W)*CNT_W | Per-bank saturating page-switch counters |

## Verification
A corrupted open-page register shows up at the next access to that bank. That access gets the wrong verdict on `cpl_hit` and the wrong completion delay, 3 cycles instead of 7 or the reverse. If the wrong counter is touched, a counter also moves when it should not. A fault in the latency timer shifts or repeats the `cpl_valid` pulse, or lets `req_ready` rise early, and that is visible within a single request. The bench replays every bank/page pairing, interleaved traffic, requests pushed in while busy, and counter saturation against an arithmetic model, and compares after every completion.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic {
    VERDICT_MISS = 1'b0,
    VERDICT_HIT  = 1'b1
  } verdict_e;
endpackage

// File: rtl/spt_bank_slot.sv
module spt_bank_slot #(
  parameter int PAGE_W = 18,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [PAGE_W-1:0] page_in,
  output logic              hit,
  output logic [CNT_W-1:0]  cnt
);
  logic              open_q;
  logic [PAGE_W-1:0] page_q;
  logic              switch_w;

  assign hit      = open_q && (page_q == page_in);
  assign switch_w = sel && open_q && (page_q != page_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      page_q <= '0;
    end else if (sel) begin
      open_q <= 1'b1;
      page_q <= page_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (switch_w && (cnt != {CNT_W{1'b1}}))
      cnt <= cnt + 1'b1;
  end

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1));
  assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {CNT_W{1'b1}}) |=> (cnt == {CNT_W{1'b1}}));
  assert_first_open_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $stable(cnt));
  assert_page_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sel) |-> $stable(page_q));
endmodule

// File: rtl/spt_lat_timer.sv
module spt_lat_timer #(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W-1:0] lat,
  output logic             busy,
  output logic             done
);
  logic [LAT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      left_q <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        left_q <= lat - 1'b1;
      end else if (busy) begin
        if (left_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

// File: rtl/sdram_page_tracker.sv
module sdram_page_tracker #(
  parameter int ADDR_W     = 32,
  parameter int BANK_W     = 2,
  parameter int OFFSET_W   = 12,
  parameter int HIT_LAT    = 3,
  parameter int SWITCH_PEN = 4,
  parameter int CNT_W      = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [ADDR_W-1:0]                req_addr,
  output logic                             cpl_valid,
  output logic                             cpl_hit,
  output logic                             busy,
  output logic [(1<<BANK_W)*CNT_W-1:0]     thrash_cnt
);
  import spt_pkg::*;

  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int PAGE_W    = ADDR_W - OFFSET_W - BANK_W;
  localparam int MISS_LAT  = HIT_LAT + SWITCH_PEN;
  localparam int LAT_W     = $clog2(MISS_LAT + 1);

  logic                 accept;
  logic [BANK_W-1:0]    bank_idx;
  logic [PAGE_W-1:0]    page_idx;
  logic [NUM_BANKS-1:0] hit_vec;
  logic [NUM_BANKS-1:0] sel_vec;
  logic                 hit_now;
  logic [LAT_W-1:0]     lat_sel;
  logic                 timer_busy;
  verdict_e             verdict_q;

  assign bank_idx  = req_addr[OFFSET_W +: BANK_W];
  assign page_idx  = req_addr[ADDR_W-1 -: PAGE_W];
  assign accept    = req_valid && !timer_busy;
  assign req_ready = !timer_busy;
  assign busy      = timer_busy;
  assign hit_now   = hit_vec[bank_idx];
  assign lat_sel   = hit_now ? LAT_W'(HIT_LAT) : LAT_W'(MISS_LAT);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel_vec[b] = accept && (bank_idx == BANK_W'(b));
    spt_bank_slot #(
      .PAGE_W (PAGE_W),
      .CNT_W  (CNT_W)
    ) slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_vec[b]),
      .page_in (page_idx),
      .hit     (hit_vec[b]),
      .cnt     (thrash_cnt[b*CNT_W +: CNT_W])
    );
  end

  spt_lat_timer #(
    .LAT_W (LAT_W)
  ) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .lat   (lat_sel),
    .busy  (timer_busy),
    .done  (cpl_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      verdict_q <= VERDICT_MISS;
    else if (accept)
      verdict_q <= hit_now ? VERDICT_HIT : VERDICT_MISS;
  end

  assign cpl_hit = (verdict_q == VERDICT_HIT);

  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));
  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> $stable(thrash_cnt));
  assert_verdict_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> $stable(cpl_hit));
endmodule

// File: tb/sdram_page_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram_page_tracker_tb_top;
  localparam int AW = 16;
  localparam int CW = 4;
  localparam int HIT_L = 3;
  localparam int MISS_L = 3 + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          cpl_valid;
  logic          cpl_hit;
  logic          busy;
  logic [4*CW-1:0] thrash_cnt;

  int n_cmp = 0;
  int n_bad = 0;
  bit m_open [4];
  int m_page [4];
  int m_cnt  [4];

  always #4 clk = ~clk;

  sdram_page_tracker #(
    .ADDR_W(AW), .BANK_W(2), .OFFSET_W(12),
    .HIT_LAT(3), .SWITCH_PEN(4), .CNT_W(CW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .cpl_valid(cpl_valid), .cpl_hit(cpl_hit),
    .busy(busy), .thrash_cnt(thrash_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_counters(input string req);
    for (int b = 0; b < 4; b++) begin
      int got;
      got = int'(thrash_cnt[b*CW +: CW]);
      chk(got == m_cnt[b], req, got, m_cnt[b]);
    end
  endtask

  task automatic do_access(input int page, input int bank, input int offs, input bit poke);
    logic [AW-1:0] a;
    bit exp_hit;
    int exp_lat;
    int n;
    bit got;
    bit was_open;
    a = {page[1:0], bank[1:0], offs[11:0]};
    was_open = m_open[bank];
    exp_hit = m_open[bank] && (m_page[bank] == page);
    exp_lat = exp_hit ? HIT_L : MISS_L;
    if (m_open[bank] && !exp_hit && m_cnt[bank] != (1 << CW) - 1) m_cnt[bank]++;
    m_open[bank] = 1'b1;
    m_page[bank] = page;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    n = 0;
    got = 1'b0;
    while (!got && n < 40) begin
      @(negedge clk);
      req_valid = poke && (n < 2);
      req_addr  = a ^ 16'hC000;
      if (cpl_valid) got = 1'b1;
      else begin
        if (req_ready || !busy) chk(1'b0, "R8 busy window", int'(req_ready), 0);
        n++;
      end
    end
    req_valid = 1'b0;
    chk(got && n == exp_lat, exp_hit ? "R3 hit latency" : (was_open ? "R4 miss latency" : "R2 first-access latency"), n, exp_lat);
    chk(cpl_hit == exp_hit, exp_hit ? "R1 R3 R5 verdict" : "R1 R4 R5 verdict", int'(cpl_hit), int'(exp_hit));
    chk_counters("R6 R7 counters");
    @(negedge clk);
    chk(cpl_valid == 1'b0, "R9 single pulse", int'(cpl_valid), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 1'b0; m_page[b] = 0; m_cnt[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
    chk(cpl_valid == 1'b0, "R10 no completion after reset", int'(cpl_valid), 0);
    chk_counters("R10 counters after reset");

    // R2: first touch of each bank
    for (int b = 0; b < 4; b++) do_access(b, b, 17 * b, 1'b0);

    // R1 R3 R4 R6: every bank/page pairing, second access a hit with another offset
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 4; p++)
        for (int r = 0; r < 2; r++)
          do_access(p, b, b * 37 + p * 5 + r * 1000, 1'b0);

    // R5 R8: interleaved banks, pushes while busy on odd steps
    for (int i = 0; i < 48; i++)
      do_access((i / 4 + i / 16) % 4, i % 4, i * 83, i[0]);

    // R7: hammer bank 2 until saturation
    for (int i = 0; i < 22; i++) do_access(i % 2, 2, i, 1'b0);

    // R5: other banks still hold their pages after the hammering
    for (int b = 0; b < 4; b++) do_access(m_page[b], b, 4095, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule